// File: doc/BRIEF.md
# Burst Word Address Sequencer

This block produces the word address that a synchronous memory array uses during a four-beat burst. An access begins when either of two independent load strobes is high at a clock edge. The external address is then captured and the beat index returns to zero. On each later edge where the step input is high, the beat index moves forward by one. The low address bits follow the beat in one of two orders, chosen by a static order input. The bits above the burst field stay at their loaded value for the whole burst.

A caller does not have to use bursts. A new address can be loaded on every cycle, and each load takes effect at once with no idle cycle. The order input is held at its setting for normal use. When it is low, the block counts in interleaved order, which is also the safe default for a tie-off. When it is high, the block counts in linear order. Both outputs come from registers through a small amount of combinational mapping. They therefore reflect the state that the most recent clock edge set up.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset (rst_n low, active low, asynchronous) is applied and after it is released, addr_o and beat_o are all zeros until the first load.
- R2: A clock edge with ld_a_i or ld_b_i high captures addr_i, so after that edge addr_o equals the captured address and beat_o is 0.
- R3: When both ld_a_i and ld_b_i are high at the same edge, the result is one load, identical to the result of either strobe alone.
- R4: An edge with step_i high and both strobes low increments beat_o by one modulo 4, so beat 3 is followed by beat 0.
- R5: With order_lin_i = 1 (linear), addr_o[1:0] equals (loaded low two bits + beat_o) modulo 4. For example, a start of 1 gives 1,2,3,0.
- R6: With order_lin_i = 0 (interleaved), addr_o[1:0] equals the loaded low two bits XOR beat_o. For example, a start of 1 gives 1,0,3,2.
- R7: addr_o bits above bit 1 keep their loaded value on every edge without a load.
- R8: An edge with both strobes and step_i low changes neither beat_o nor addr_o.
- R9: A load strobe takes priority over step_i at the same edge, so the beat restarts at 0 instead of advancing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_a_i | input | 1 | First load strobe |
| ld_b_i | input | 1 | Second load strobe |
| step_i | input | 1 | Advance the beat by one |
| order_lin_i | input | 1 | 1 = linear order, 0 = interleaved order |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Current word address for the array |
| beat_o | output | BEAT_W | Beat index within the burst |

## Verification
The bench builds the block with its defaults: a 20-bit address and a 2-bit beat field. With these values a four-beat wrap takes only a few steps, so the bench can reach beat-3-to-0 rollover in both orders. The start addresses use distinct low-bit values (1, 2 and 3) and different upper patterns. These show the difference between the additive order and the XOR order, and confirm that the upper bits never move within a burst.

// File: rtl/burst_pkg.sv
package burst_pkg;
    typedef enum logic {
        ORD_INTERLEAVED = 1'b0,
        ORD_LINEAR      = 1'b1
    } burst_order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    output logic [BEAT_W-1:0] beat_o
);
    typedef struct packed {
        logic [BEAT_W-1:0] beat;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.beat = '0;
        end else if (step_i) begin
            st_d.beat = st_q.beat + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign beat_o = st_q.beat;
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start_i,
    input  logic [BEAT_W-1:0] beat_i,
    input  burst_order_e      order_i,
    output logic [BEAT_W-1:0] low_o
);
    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] ilv_low;

    assign lin_low = start_i + beat_i;

    for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv_bit
        assign ilv_low[b] = start_i[b] ^ beat_i[b];
    end

    always_comb begin
        if (order_i == ORD_LINEAR) begin
            low_o = lin_low;
        end else begin
            low_o = ilv_low;
        end
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_a_i,
    input  logic              ld_b_i,
    input  logic              step_i,
    input  logic              order_lin_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BEAT_W-1:0] beat_o
);
    localparam int HI_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
    } base_state_t;

    base_state_t  st_d, st_q;
    logic         load;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] low;
    burst_order_e order;

    assign load  = ld_a_i | ld_b_i;
    assign order = burst_order_e'(order_lin_i);

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.base = addr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .step_i (step_i),
        .beat_o (beat)
    );

    burst_order_map #(.BEAT_W(BEAT_W)) u_map (
        .start_i (st_q.base[BEAT_W-1:0]),
        .beat_i  (beat),
        .order_i (order),
        .low_o   (low)
    );

    assign addr_o = {st_q.base[ADDR_W-1 -: HI_W], low};
    assign beat_o = beat;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_a_i,
    input logic              ld_b_i,
    input logic              step_i,
    input logic              order_lin_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic [BEAT_W-1:0] beat_o
);
    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_a_i || ld_b_i) |=> (addr_o == $past(addr_i)) && (beat_o == '0));

    // R4
    beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !ld_a_i && !ld_b_i) |=> beat_o == BEAT_W'($past(beat_o) + 1'b1));

    // R8
    hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !ld_a_i && !ld_b_i) |=> $stable(beat_o));

    // R7
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_a_i && !ld_b_i) |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

    // R5
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !ld_a_i && !ld_b_i && order_lin_i) |=>
        (!order_lin_i || addr_o[BEAT_W-1:0] == BEAT_W'($past(addr_o[BEAT_W-1:0]) + 1'b1)));

    // R6
    interleave_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !ld_a_i && !ld_b_i && !order_lin_i) |=>
        (order_lin_i || addr_o[0] != $past(addr_o[0])));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_a_i      (ld_a_i),
    .ld_b_i      (ld_b_i),
    .step_i      (step_i),
    .order_lin_i (order_lin_i),
    .addr_i      (addr_i),
    .addr_o      (addr_o),
    .beat_o      (beat_o)
);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
    localparam int ADDR_W = 20;
    localparam int BEAT_W = 2;

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic [BEAT_W-1:0] beat;
        string             tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ld_a_i = 1'b0;
    logic              ld_b_i = 1'b0;
    logic              step_i = 1'b0;
    logic              order_lin_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [ADDR_W-1:0] addr_o;
    logic [BEAT_W-1:0] beat_o;

    exp_t              sb[$];
    int                checks = 0;
    int                errors = 0;
    bit                done = 1'b0;
    logic [ADDR_W-1:0] m_base = '0;
    logic [BEAT_W-1:0] m_beat = '0;

    always #4 clk = ~clk;

    burst_addr_gen #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) uut (
        .clk(clk), .rst_n(rst_n), .ld_a_i(ld_a_i), .ld_b_i(ld_b_i),
        .step_i(step_i), .order_lin_i(order_lin_i), .addr_i(addr_i),
        .addr_o(addr_o), .beat_o(beat_o)
    );

    task automatic compare(input exp_t e);
        checks++;
        if (addr_o !== e.addr || beat_o !== e.beat) begin
            errors++;
            $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                     e.tag, addr_o, beat_o, e.addr, e.beat);
        end
    endtask

    task automatic drive(input logic a, input logic b, input logic st,
                         input logic lin, input logic [ADDR_W-1:0] ad,
                         input string tag);
        exp_t e;
        logic [BEAT_W-1:0] lo;
        @(negedge clk);
        ld_a_i = a; ld_b_i = b; step_i = st; order_lin_i = lin; addr_i = ad;
        @(posedge clk);
        #1;
        if (a || b) begin
            m_base = ad;
            m_beat = '0;
        end else if (st) begin
            m_beat = m_beat + 1'b1;
        end
        lo = lin ? BEAT_W'(m_base[BEAT_W-1:0] + m_beat) : (m_base[BEAT_W-1:0] ^ m_beat);
        e.addr = {m_base[ADDR_W-1:BEAT_W], lo};
        e.beat = m_beat;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    // monitor: pops one expected item per cycle after the edge settles
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) compare(sb.pop_front());
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        exp_t r;
        #10;
        r.addr = '0; r.beat = '0; r.tag = "R1 in reset";
        compare(r);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        r.tag = "R1 after release";
        compare(r);

        // linear burst from low bits 1, strobe A
        drive(1, 0, 0, 1, 20'h12345, "R2 load via A");
        drive(0, 0, 1, 1, 20'h0, "R5 linear beat1");
        drive(0, 0, 1, 1, 20'h0, "R5 linear beat2");
        drive(0, 0, 0, 1, 20'hFFFFF, "R8 hold");
        drive(0, 0, 1, 1, 20'h0, "R4 R5 linear wrap to 0");
        drive(0, 0, 1, 1, 20'h0, "R4 beat rollover 3->0");
        drive(0, 0, 1, 1, 20'h0, "R7 upper fixed");

        // interleaved burst from low bits 2, strobe B
        drive(0, 1, 0, 0, 20'hABCDE, "R2 load via B");
        drive(0, 0, 1, 0, 20'h0, "R6 interleaved beat1");
        drive(0, 0, 1, 0, 20'h0, "R6 interleaved beat2");
        drive(0, 0, 1, 0, 20'h0, "R6 interleaved beat3");
        drive(0, 0, 0, 0, 20'h55555, "R8 hold interleaved");
        drive(0, 0, 1, 0, 20'h0, "R4 R7 interleaved rollover");

        // interleaved from low bits 1
        drive(1, 0, 0, 0, 20'h00001, "R2 load start 1");
        drive(0, 0, 1, 0, 20'h0, "R6 start1 beat1");
        drive(0, 0, 1, 0, 20'h0, "R6 start1 beat2");
        drive(0, 0, 1, 0, 20'h0, "R6 start1 beat3");

        // both strobes plus step in the same cycle
        drive(1, 1, 1, 1, 20'h70003, "R3 R9 dual strobe with step");
        drive(0, 0, 1, 1, 20'h0, "R5 linear from 3");
        drive(1, 0, 1, 1, 20'h00002, "R9 load beats step mid-burst");
        drive(0, 0, 1, 1, 20'h0, "R5 linear from 2");
        drive(0, 1, 1, 0, 20'hFFFFF, "R3 back-to-back load");

        @(negedge clk);
        ld_a_i = 0; ld_b_i = 0; step_i = 0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule